// File: doc/BRIEF.md
# RMII receive frame capture

This block receives Ethernet frames from a PHY over the reduced media-independent interface (RMII). It watches the combined carrier-sense/data-valid line and the two receive data bits. The logic runs on a fast system clock. A sample enable `smp_en` marks the 100 MHz sampling instants, so each 50 MHz RMII data period holds two enabled edges. The inputs can first pass through two-flop synchronizers, chosen by a parameter.

Once carrier appears, the block looks for the preamble. The preamble starts when bit 0 goes high. The start-of-frame delimiter is marked when bit 1 goes high. After the delimiter the block lets a fixed number of sample ticks pass so that it lands at a stable point in each data period. It then takes one di-bit every second tick. Di-bits are packed into bytes, and the bytes are streamed out with valid, first and last flags and two error flags. A one-cycle end pulse marks each frame that ends after a delimiter was found. Checking the frame check sequence, filtering addresses, the 10 Mbit mode and PHY management are left to other logic.

Top module: `rmii_rx_capture`

## Requirements
- R1: During and after a synchronous active-high reset, every output is low until a frame has been received.
- R2: While `crs_dv` is low, activity on `rxd` produces no byte and no `frame_end`, and it does not disturb the next frame.
- R3: After carrier rises, di-bits with `rxd[0]`=0 are ignored, even when they have `rxd[1]`=1. The preamble is accepted at the first sample with `rxd[0]`=1. The delimiter is accepted at the next sample with `rxd[1]`=1.
- R4: After the delimiter sample, the block skips ALIGN_TICKS (2) enabled ticks and then captures one di-bit on every second enabled tick. This yields exactly one di-bit per 50 MHz data period.
- R5: Di-bits are packed least significant first. The first di-bit of a byte becomes bits [1:0] and the fourth becomes bits [7:6]. A byte is complete after four di-bits.
- R6: Each complete byte appears for one cycle with `out_valid` high. `out_first` is set on the first byte of a frame and `out_last` on the final complete byte. Bytes come out in the order received.
- R7: A frame ends with 1 to 3 leftover di-bits. Those di-bits are discarded, and `out_err_align` is set together with `out_last` on the final complete byte.
- R8: A frame of fewer than MIN_LEN (64) or more than MAX_LEN (1522) complete bytes has `out_err_len` set on its last byte. Frames of exactly 64 or 1522 bytes are not flagged. Error flags are never set without `out_last`.
- R9: A frame ends when `crs_dv` is low at a capture point. `frame_end` then pulses for exactly one cycle, in the same cycle as the `out_last` byte. The pulse also occurs when no byte was completed.
- R10: If carrier drops before the delimiter is seen, the block returns to idle with no byte and no `frame_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable at twice the RMII reference rate |
| crs_dv | input | 1 | Carrier sense / data valid from the PHY |
| rxd | input | 2 | Receive di-bit from the PHY |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Received byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Final complete byte of a frame |
| out_err_len | output | 1 | Frame length out of range (with last) |
| out_err_align | output | 1 | Trailing partial byte dropped (with last) |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that the sample enable is a regular pulse train and that the PHY changes `crs_dv` and `rxd` only at 50 MHz period boundaries. Under those conditions a capture point always has a full tick between itself and the next one, and the end of a frame can only come from a capture point. The stimulus drives every di-bit through one task. That task holds the di-bit for four clocks and raises the enable on the first and third of them, so both instances (with and without synchronizers) see two ticks per period. Neither instance ever sees an input change between two ticks of the same period.

// File: rtl/rmii_cap_pkg.sv
package rmii_cap_pkg;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_PREAMBLE,
    CAP_DELIM,
    CAP_ALIGN,
    CAP_RECV
  } cap_state_e;

  localparam int unsigned DIBITS_PER_BYTE = 4;

endpackage

// File: rtl/rmii_cap_sync.sv
module rmii_cap_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  if (STAGES == 0) begin : g_bypass
    assign dout = din;
  end else begin : g_chain
    logic [WIDTH-1:0] stage_q [STAGES];
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= '0;
          else     stage_q[i] <= din;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= '0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
    assign dout = stage_q[STAGES-1];
  end

endmodule

// File: rtl/rmii_cap_frame.sv
module rmii_cap_frame
  import rmii_cap_pkg::*;
#(
  parameter int unsigned ALIGN_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_en,
  input  logic       dv,
  input  logic [1:0] rxd,
  output logic       dibit_stb,
  output logic [1:0] dibit,
  output logic       end_stb
);

  localparam int unsigned SKIP_W = (ALIGN_TICKS < 2) ? 1 : $clog2(ALIGN_TICKS + 1);
  localparam logic [SKIP_W-1:0] SKIP_LOAD = SKIP_W'(ALIGN_TICKS);
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(1);

  cap_state_e        state;
  logic [SKIP_W-1:0] skip_cnt;
  logic              take_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_IDLE;
      skip_cnt  <= '0;
      take_next <= 1'b0;
      dibit_stb <= 1'b0;
      dibit     <= 2'b00;
      end_stb   <= 1'b0;
    end else begin
      dibit_stb <= 1'b0;
      end_stb   <= 1'b0;
      if (smp_en) begin
        unique case (state)
          CAP_IDLE: begin
            if (dv) state <= CAP_PREAMBLE;
          end
          CAP_PREAMBLE: begin
            if (!dv)         state <= CAP_IDLE;
            else if (rxd[0]) state <= CAP_DELIM;
          end
          CAP_DELIM: begin
            if (!dv) begin
              state <= CAP_IDLE;
            end else if (rxd[1]) begin
              skip_cnt <= SKIP_LOAD;
              state    <= CAP_ALIGN;
            end
          end
          CAP_ALIGN: begin
            skip_cnt <= skip_cnt - SKIP_LAST;
            if (skip_cnt <= SKIP_LAST) begin
              state     <= CAP_RECV;
              take_next <= 1'b1;
            end
          end
          CAP_RECV: begin
            take_next <= ~take_next;
            if (take_next) begin
              if (dv) begin
                dibit_stb <= 1'b1;
                dibit     <= rxd;
              end else begin
                end_stb   <= 1'b1;
                take_next <= 1'b0;
                state     <= CAP_IDLE;
              end
            end
          end
          default: state <= CAP_IDLE;
        endcase
      end
    end
  end

  AST_DIBIT_SPACING: assert property (@(posedge clk) disable iff (rst)
    dibit_stb |=> !dibit_stb); // R4

  AST_END_NOT_NEXT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    end_stb |=> !dibit_stb); // R9

endmodule

// File: rtl/rmii_cap_pack.sv
module rmii_cap_pack
  import rmii_cap_pkg::*;
#(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1522
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dibit_stb,
  input  logic [1:0] dibit,
  input  logic       end_stb,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last,
  output logic       out_err_len,
  output logic       out_err_align,
  output logic       frame_end
);

  localparam int unsigned LEN_W = $clog2(MAX_LEN + 2);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(MAX_LEN + 1);
  localparam logic [1:0] SLOT_LAST = 2'(DIBITS_PER_BYTE - 1);

  logic [7:0]       shift_q;
  logic [7:0]       shift_next;
  logic [1:0]       slot_q;
  logic [7:0]       held_data;
  logic             held_vld;
  logic             held_first;
  logic [LEN_W-1:0] len_cnt;
  logic             len_bad;

  assign shift_next = {dibit, shift_q[7:2]};
  assign len_bad    = (len_cnt < LEN_MIN) || (len_cnt > LEN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q       <= '0;
      slot_q        <= '0;
      held_data     <= '0;
      held_vld      <= 1'b0;
      held_first    <= 1'b0;
      len_cnt       <= '0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_first     <= 1'b0;
      out_last      <= 1'b0;
      out_err_len   <= 1'b0;
      out_err_align <= 1'b0;
      frame_end     <= 1'b0;
    end else begin
      out_valid     <= 1'b0;
      out_first     <= 1'b0;
      out_last      <= 1'b0;
      out_err_len   <= 1'b0;
      out_err_align <= 1'b0;
      frame_end     <= end_stb;
      if (end_stb) begin
        if (held_vld) begin
          out_valid     <= 1'b1;
          out_data      <= held_data;
          out_first     <= held_first;
          out_last      <= 1'b1;
          out_err_len   <= len_bad;
          out_err_align <= (slot_q != 2'd0);
        end
        held_vld <= 1'b0;
        slot_q   <= '0;
        shift_q  <= '0;
        len_cnt  <= '0;
      end else if (dibit_stb) begin
        shift_q <= shift_next;
        slot_q  <= slot_q + 2'd1;
        if (slot_q == SLOT_LAST) begin
          if (held_vld) begin
            out_valid <= 1'b1;
            out_data  <= held_data;
            out_first <= held_first;
          end
          held_data  <= shift_next;
          held_vld   <= 1'b1;
          held_first <= (len_cnt == '0);
          if (len_cnt != LEN_TOP) len_cnt <= len_cnt + 1'b1;
        end
      end
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R6

  AST_ERR_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_err_len || out_err_align) |-> out_last); // R8

  AST_LAST_FOLLOWS_END: assert property (@(posedge clk) disable iff (rst)
    out_last |-> $past(end_stb)); // R9

  AST_END_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end); // R9

endmodule

// File: rtl/rmii_rx_capture.sv
module rmii_rx_capture
  import rmii_cap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ALIGN_TICKS = 2,
  parameter int unsigned MIN_LEN     = 64,
  parameter int unsigned MAX_LEN     = 1522
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_en,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last,
  output logic       out_err_len,
  output logic       out_err_align,
  output logic       frame_end
);

  logic [2:0] pins_s;
  logic       dibit_stb;
  logic [1:0] dibit;
  logic       end_stb;

  rmii_cap_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({crs_dv, rxd}),
    .dout (pins_s)
  );

  rmii_cap_frame #(
    .ALIGN_TICKS (ALIGN_TICKS)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .dv        (pins_s[2]),
    .rxd       (pins_s[1:0]),
    .dibit_stb (dibit_stb),
    .dibit     (dibit),
    .end_stb   (end_stb)
  );

  rmii_cap_pack #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_pack (
    .clk           (clk),
    .rst           (rst),
    .dibit_stb     (dibit_stb),
    .dibit         (dibit),
    .end_stb       (end_stb),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_first     (out_first),
    .out_last      (out_last),
    .out_err_len   (out_err_len),
    .out_err_align (out_err_align),
    .frame_end     (frame_end)
  );

endmodule

// File: tb/rmii_rx_capture_bench.sv
`timescale 1ns/1ps
module rmii_rx_capture_bench;

  typedef struct {
    logic [7:0] d;
    logic       f;
    logic       l;
    logic       el;
    logic       ea;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;

  always #2.5 clk = ~clk;

  logic       va, fa, la, ela, eaa, ea_end;
  logic [7:0] da;
  logic       vb, fb, lb, elb, eab, eb_end;
  logic [7:0] db;

  rmii_rx_capture u_rmii_rx_capture (
    .clk(clk), .rst(rst), .smp_en(smp_en), .crs_dv(crs_dv), .rxd(rxd),
    .out_valid(va), .out_data(da), .out_first(fa), .out_last(la),
    .out_err_len(ela), .out_err_align(eaa), .frame_end(ea_end));

  rmii_rx_capture #(.SYNC_STAGES(0)) u_rmii_rx_capture_nosync (
    .clk(clk), .rst(rst), .smp_en(smp_en), .crs_dv(crs_dv), .rxd(rxd),
    .out_valid(vb), .out_data(db), .out_first(fb), .out_last(lb),
    .out_err_len(elb), .out_err_align(eab), .frame_end(eb_end));

  exp_t qa[$];
  exp_t qb[$];
  int checks = 0;
  int errors = 0;
  int seen_a = 0, seen_b = 0;
  int eop_a = 0, eop_b = 0;
  int exp_eop = 0;
  bit done = 1'b0;

  task automatic note(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic cmp(input string who, input exp_t e, input logic [7:0] d,
                     input logic f, input logic l, input logic el, input logic ea);
    checks++;
    if ({d, f, l, el, ea} !== {e.d, e.f, e.l, e.el, e.ea}) begin
      errors++;
      $display("FAIL %s %s: got d=%02h first=%0b last=%0b elen=%0b ealign=%0b expected d=%02h first=%0b last=%0b elen=%0b ealign=%0b",
               e.tag, who, d, f, l, el, ea, e.d, e.f, e.l, e.el, e.ea);
    end
  endtask

  // Per-clock comparison against the behavioural expectation queues
  always @(negedge clk) begin
    if (!rst) begin
      if (va) begin
        seen_a++;
        if (qa.size() == 0) note(1'b0, $sformatf("R6 sync: unexpected byte got %02h expected none", da));
        else cmp("sync", qa.pop_front(), da, fa, la, ela, eaa);
        if (la) note(ea_end, $sformatf("R9 sync: frame_end with last got %0b expected 1", ea_end));
      end
      if (vb) begin
        seen_b++;
        if (qb.size() == 0) note(1'b0, $sformatf("R6 nosync: unexpected byte got %02h expected none", db));
        else cmp("nosync", qb.pop_front(), db, fb, lb, elb, eab);
        if (lb) note(eb_end, $sformatf("R9 nosync: frame_end with last got %0b expected 1", eb_end));
      end
      if (ea_end) eop_a++;
      if (eb_end) eop_b++;
    end
  end

  // One RMII di-bit period: four system clocks, enable on the first and third
  task automatic put_dibit(input logic dv, input logic [1:0] d);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin
        crs_dv = dv;
        rxd    = d;
      end
      smp_en = (k == 0 || k == 2);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) put_dibit(1'b1, b[2*k +: 2]);
  endtask

  function automatic logic [7:0] byte_of(input int i, input int seed);
    return 8'((i * 37) + (seed * 11) + (i >> 3));
  endfunction

  task automatic send_frame(input int n, input int extra, input int seed,
                            input bit noise, input string ftag);
    exp_t e;
    put_dibit(1'b1, 2'b00);
    put_dibit(1'b1, 2'b00);
    if (noise) begin
      put_dibit(1'b1, 2'b10);
      put_dibit(1'b1, 2'b10);
      put_dibit(1'b1, 2'b00);
    end
    for (int p = 0; p < 7; p++) put_byte(8'h55);
    put_byte(8'hD5);
    for (int i = 0; i < n; i++) begin
      e.d  = byte_of(i, seed);
      e.f  = (i == 0);
      e.l  = (i == n - 1);
      e.el = e.l && (n < 64 || n > 1522);
      e.ea = e.l && (extra != 0);
      if (e.l)       e.tag = e.ea ? "R7" : (e.el ? "R8" : "R6");
      else if (i==0) e.tag = ftag;
      else           e.tag = "R4 R5";
      qa.push_back(e);
      qb.push_back(e);
      put_byte(e.d);
    end
    for (int x = 0; x < extra; x++) put_dibit(1'b1, 2'(x + 1));
    for (int x = 0; x < 4; x++) put_dibit(1'b0, 2'b00);
    exp_eop++;
    note(qa.size() == 0 && qb.size() == 0,
         $sformatf("R6 bytes still pending got %0d/%0d expected 0", qa.size(), qb.size()));
    note(eop_a == exp_eop && eop_b == exp_eop,
         $sformatf("R9 frame_end count got %0d/%0d expected %0d", eop_a, eop_b, exp_eop));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    finish_run();
  end

  initial begin
    int sa, sb;
    for (int r = 0; r < 4; r++) put_dibit(1'b0, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    put_dibit(1'b0, 2'b00);
    // R1: quiet outputs after reset
    note({va, da, fa, la, ela, eaa, ea_end, vb, db, fb, lb, elb, eab, eb_end} == '0,
         $sformatf("R1 reset outputs got %02h/%02h expected 0", da, db));

    // R2: data toggling without carrier
    sa = seen_a; sb = seen_b;
    put_dibit(1'b0, 2'b01); put_dibit(1'b0, 2'b11);
    put_dibit(1'b0, 2'b10); put_dibit(1'b0, 2'b11);
    put_dibit(1'b0, 2'b00);
    note(seen_a == sa && seen_b == sb && eop_a == 0 && eop_b == 0,
         $sformatf("R2 activity without carrier got %0d bytes %0d ends expected 0", seen_a - sa, eop_a));

    // R10: carrier lost during preamble
    put_dibit(1'b1, 2'b00);
    put_dibit(1'b1, 2'b01); put_dibit(1'b1, 2'b01); put_dibit(1'b1, 2'b01);
    for (int x = 0; x < 3; x++) put_dibit(1'b0, 2'b00);
    note(seen_a == sa && seen_b == sb && eop_a == 0 && eop_b == 0,
         $sformatf("R10 aborted preamble got %0d bytes %0d ends expected 0", seen_a - sa, eop_a));

    send_frame(64, 0, 1, 1'b0, "R6");    // minimum length, no flags
    send_frame(63, 0, 2, 1'b0, "R6");    // R8 short frame
    send_frame(70, 3, 3, 1'b0, "R6");    // R7 three leftover di-bits
    send_frame(80, 1, 4, 1'b0, "R6");    // R7 one leftover di-bit
    send_frame(100, 0, 5, 1'b1, "R3");   // R3 di-bits with rxd[1] only before preamble
    sa = seen_a;
    send_frame(0, 0, 6, 1'b0, "R9");     // R9 end pulse without any byte
    note(seen_a == sa, $sformatf("R9 empty frame bytes got %0d expected 0", seen_a - sa));
    send_frame(1522, 0, 7, 1'b0, "R8");  // upper bound, not flagged
    send_frame(1523, 0, 8, 1'b0, "R8");  // R8 long frame
    finish_run();
  end

endmodule